// File: doc/BRIEF.md
# One-Wire Slave Bit Timing Front End

This block sits between a synchronized open-drain data line and the byte and command logic of a one-wire slave. It watches the line, measured in microsecond ticks supplied from outside, and turns low pulses into events: bus resets (answered with a presence pulse), write slots (decoded into received bits) and read slots (into which it drives the transmit bit by holding the line low for a zero). The line is modelled as an input plus a drive-low output; the pull-up lives outside.

Two timing sets exist, standard and overdrive. The speed-select level is captured at the falling edge that opens each low pulse and is committed only when that pulse qualifies as a reset, so one speed governs the whole transaction that follows. A separate detector raises a sleep request when the line stays low for a long, parameterized time while a sleep enable is set.

Top module: `owire_bit_phy`

## Requirements
- R1: A low of at least 480 ticks (standard) or 48 ticks (overdrive, speed-select 1 at the falling edge) followed by a rise produces a one-cycle `bus_reset` pulse; a shorter low produces none.
- R2: After a qualifying reset the line is left alone for 30 ticks (standard) or 3 ticks (overdrive) after its rise, then `drive_low` is held for 120 ticks (standard) or 16 ticks (overdrive), each within one tick.
- R3: `od_mode` changes only together with `bus_reset` and takes the speed-select value seen at that reset's falling edge; speed-select changes between resets have no effect on slot timing.
- R4: With `tx_en` low at a slot's falling edge, the line level 30 ticks (standard) or 3 ticks (overdrive) after the fall is reported as `rx_bit` with a one-cycle `rx_valid`; high means 1.
- R5: With `tx_en` high at the falling edge and `tx_bit` 0, `drive_low` is held from the fall until 30 ticks (standard) or 3 ticks (overdrive) after it; with `tx_bit` 1 the line is not driven; read slots give no `rx_valid`.
- R6: A low lasting 120 ticks (standard) or 16 ticks (overdrive, per `od_mode`) produces exactly one `xact_abort` pulse in that low and releases any drive.
- R7: With `sleep_en` set, `sleep_req` rises once the line has been low for `T_SLEEP` ticks and falls when the line goes high; with `sleep_en` clear it stays low.
- R8: After reset `drive_low`, `sleep_req`, `od_mode` are 0 and no event pulse is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| us_tick | input | 1 | One-cycle pulse every microsecond |
| line_in | input | 1 | Data line level, asynchronous |
| speed_sel | input | 1 | 1 selects overdrive timing |
| sleep_en | input | 1 | Allows the long-low sleep request |
| tx_en | input | 1 | Next slot is a read slot driven from tx_bit |
| tx_bit | input | 1 | Bit to send in a read slot |
| drive_low | output | 1 | Pull the line low |
| rx_valid | output | 1 | One-cycle strobe for rx_bit |
| rx_bit | output | 1 | Decoded write-slot bit |
| bus_reset | output | 1 | One-cycle pulse on a qualified reset |
| xact_abort | output | 1 | One-cycle pulse when a low exceeds the slot limit |
| od_mode | output | 1 | Speed committed at the last reset |
| sleep_req | output | 1 | Long-low sleep request |

## Verification
The bench drives a wired-AND line shared with the design and walks write-0, write-1, read-0 and read-1 slots at both speeds, so a design that sampled at the wrong point or used the wrong speed decodes the wrong bit or lets a read-zero show as one. It changes speed-select without a reset and then runs an overdrive write-0, which a design reading the live input would sample far too late and decode as 1. Lows that exceed the slot limit but not the reset limit must abort without a presence pulse, and presence delay and width are counted in ticks, catching swapped or mis-selected timing sets. The sleep request is probed just before and after its threshold and again after the line rises, and with the enable clear.

// File: rtl/owb_pkg.sv
package owb_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SLOT,
        ST_PD_WAIT,
        ST_PD_LOW,
        ST_PD_REL
    } owb_state_e;
endpackage

// File: rtl/owb_sync.sv
module owb_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    output logic line_s,
    output logic fall,
    output logic rise
);
    logic [STAGES-1:0] chain_d, chain_q;
    logic              prev_d, prev_q;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], line_in};
        prev_d  = chain_q[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '1;
            prev_q  <= 1'b1;
        end else begin
            chain_q <= chain_d;
            prev_q  <= prev_d;
        end
    end

    assign line_s = chain_q[STAGES-1];
    assign fall   = prev_q & ~line_s;
    assign rise   = ~prev_q & line_s;
endmodule

// File: rtl/owb_sleep_det.sv
module owb_sleep_det #(
    parameter int T_SLEEP = 2000000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic us_tick,
    input  logic line_s,
    input  logic sleep_en,
    output logic sleep_req
);
    localparam int SL_W = $clog2(T_SLEEP + 1);

    typedef struct packed {
        logic [SL_W-1:0] cnt;
        logic            req;
    } sleep_t;

    sleep_t d, q;

    always_comb begin
        d = q;
        if (line_s) begin
            d.cnt = '0;
            d.req = 1'b0;
        end else begin
            if (us_tick && q.cnt < SL_W'(T_SLEEP))
                d.cnt = q.cnt + 1'b1;
            if (sleep_en && q.cnt >= SL_W'(T_SLEEP))
                d.req = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign sleep_req = q.req;
endmodule

// File: rtl/owb_slot_fsm.sv
module owb_slot_fsm
    import owb_pkg::*;
#(
    parameter int CNT_W      = 10,
    parameter int T_RST_STD  = 480,
    parameter int T_RST_OD   = 48,
    parameter int T_ABT_STD  = 120,
    parameter int T_ABT_OD   = 16,
    parameter int T_SMP_STD  = 30,
    parameter int T_SMP_OD   = 3,
    parameter int T_HOLD_STD = 30,
    parameter int T_HOLD_OD  = 3,
    parameter int T_PDH_STD  = 30,
    parameter int T_PDH_OD   = 3,
    parameter int T_PDL_STD  = 120,
    parameter int T_PDL_OD   = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic us_tick,
    input  logic line_s,
    input  logic fall,
    input  logic rise,
    input  logic speed_sel,
    input  logic tx_en,
    input  logic tx_bit,
    output logic drive_low,
    output logic rx_valid,
    output logic rx_bit,
    output logic bus_reset,
    output logic xact_abort,
    output logic od_mode
);
    typedef struct packed {
        owb_state_e       st;
        logic [CNT_W-1:0] cnt;   // ticks since slot fall / presence phase
        logic [CNT_W-1:0] low;   // ticks the line has been low in this slot
        logic             od;    // committed speed
        logic             cand;  // speed captured at the slot fall
        logic             rd;    // slot is a read slot
        logic             ab;    // slot already aborted
        logic             drv;
        logic             rxv;
        logic             rxb;
        logic             brst;
        logic             abp;
    } fsm_t;

    fsm_t d, q;

    logic [CNT_W-1:0] smp_t, hold_t, abt_t, pdh_t, pdl_t, rst_t;
    logic [CNT_W-1:0] cnt_nx, low_nx;

    always_comb begin
        smp_t  = q.od   ? CNT_W'(T_SMP_OD)  : CNT_W'(T_SMP_STD);
        hold_t = q.od   ? CNT_W'(T_HOLD_OD) : CNT_W'(T_HOLD_STD);
        abt_t  = q.od   ? CNT_W'(T_ABT_OD)  : CNT_W'(T_ABT_STD);
        pdh_t  = q.od   ? CNT_W'(T_PDH_OD)  : CNT_W'(T_PDH_STD);
        pdl_t  = q.od   ? CNT_W'(T_PDL_OD)  : CNT_W'(T_PDL_STD);
        rst_t  = q.cand ? CNT_W'(T_RST_OD)  : CNT_W'(T_RST_STD);
        cnt_nx = (q.cnt == '1) ? q.cnt : q.cnt + 1'b1;
        low_nx = (q.low == '1) ? q.low : q.low + 1'b1;
    end

    always_comb begin
        d      = q;
        d.rxv  = 1'b0;
        d.brst = 1'b0;
        d.abp  = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                d.drv = 1'b0;
                if (fall) begin
                    d.st   = ST_SLOT;
                    d.cnt  = '0;
                    d.low  = '0;
                    d.cand = speed_sel;
                    d.rd   = tx_en;
                    d.ab   = 1'b0;
                    d.drv  = tx_en & ~tx_bit;
                end
            end
            ST_SLOT: begin
                if (us_tick) begin
                    d.cnt = cnt_nx;
                    if (!line_s)
                        d.low = low_nx;
                    if (cnt_nx == smp_t && !q.rd && !q.ab) begin
                        d.rxv = 1'b1;
                        d.rxb = line_s;
                    end
                    if (cnt_nx == hold_t)
                        d.drv = 1'b0;
                    if (!line_s && low_nx == abt_t && !q.ab) begin
                        d.ab  = 1'b1;
                        d.abp = 1'b1;
                        d.drv = 1'b0;
                    end
                end
                if (rise && q.low >= rst_t) begin
                    d.st   = ST_PD_WAIT;
                    d.cnt  = '0;
                    d.od   = q.cand;
                    d.brst = 1'b1;
                    d.drv  = 1'b0;
                    d.rxv  = 1'b0;
                end else if (line_s && q.cnt >= smp_t && !q.drv) begin
                    d.st = ST_IDLE;
                end
            end
            ST_PD_WAIT: begin
                if (us_tick) begin
                    d.cnt = cnt_nx;
                    if (cnt_nx == pdh_t) begin
                        d.st  = ST_PD_LOW;
                        d.cnt = '0;
                        d.drv = 1'b1;
                    end
                end
            end
            ST_PD_LOW: begin
                if (us_tick) begin
                    d.cnt = cnt_nx;
                    if (cnt_nx == pdl_t) begin
                        d.st  = ST_PD_REL;
                        d.drv = 1'b0;
                    end
                end
            end
            ST_PD_REL: begin
                if (line_s)
                    d.st = ST_IDLE;
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign drive_low  = q.drv;
    assign rx_valid   = q.rxv;
    assign rx_bit     = q.rxb;
    assign bus_reset  = q.brst;
    assign xact_abort = q.abp;
    assign od_mode    = q.od;
endmodule

// File: rtl/owire_bit_phy.sv
module owire_bit_phy #(
    parameter int SYNC_STAGES = 2,
    parameter int T_RST_STD   = 480,
    parameter int T_RST_OD    = 48,
    parameter int T_ABT_STD   = 120,
    parameter int T_ABT_OD    = 16,
    parameter int T_SMP_STD   = 30,
    parameter int T_SMP_OD    = 3,
    parameter int T_HOLD_STD  = 30,
    parameter int T_HOLD_OD   = 3,
    parameter int T_PDH_STD   = 30,
    parameter int T_PDH_OD    = 3,
    parameter int T_PDL_STD   = 120,
    parameter int T_PDL_OD    = 16,
    parameter int T_SLEEP     = 2000000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic us_tick,
    input  logic line_in,
    input  logic speed_sel,
    input  logic sleep_en,
    input  logic tx_en,
    input  logic tx_bit,
    output logic drive_low,
    output logic rx_valid,
    output logic rx_bit,
    output logic bus_reset,
    output logic xact_abort,
    output logic od_mode,
    output logic sleep_req
);
    localparam int CNT_W = $clog2(T_RST_STD + 1) + 1;

    logic line_s, fall, rise;

    owb_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .line_in (line_in),
        .line_s  (line_s),
        .fall    (fall),
        .rise    (rise)
    );

    owb_slot_fsm #(
        .CNT_W      (CNT_W),
        .T_RST_STD  (T_RST_STD),
        .T_RST_OD   (T_RST_OD),
        .T_ABT_STD  (T_ABT_STD),
        .T_ABT_OD   (T_ABT_OD),
        .T_SMP_STD  (T_SMP_STD),
        .T_SMP_OD   (T_SMP_OD),
        .T_HOLD_STD (T_HOLD_STD),
        .T_HOLD_OD  (T_HOLD_OD),
        .T_PDH_STD  (T_PDH_STD),
        .T_PDH_OD   (T_PDH_OD),
        .T_PDL_STD  (T_PDL_STD),
        .T_PDL_OD   (T_PDL_OD)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .us_tick    (us_tick),
        .line_s     (line_s),
        .fall       (fall),
        .rise       (rise),
        .speed_sel  (speed_sel),
        .tx_en      (tx_en),
        .tx_bit     (tx_bit),
        .drive_low  (drive_low),
        .rx_valid   (rx_valid),
        .rx_bit     (rx_bit),
        .bus_reset  (bus_reset),
        .xact_abort (xact_abort),
        .od_mode    (od_mode)
    );

    owb_sleep_det #(.T_SLEEP(T_SLEEP)) u_sleep (
        .clk       (clk),
        .rst_n     (rst_n),
        .us_tick   (us_tick),
        .line_s    (line_s),
        .sleep_en  (sleep_en),
        .sleep_req (sleep_req)
    );
endmodule

// File: rtl/owb_phy_chk.sv
module owb_phy_chk (
    input logic clk,
    input logic rst_n,
    input logic sleep_en,
    input logic drive_low,
    input logic rx_valid,
    input logic bus_reset,
    input logic xact_abort,
    input logic od_mode,
    input logic sleep_req
);
    // R4: received-bit strobe lasts one cycle
    assert_rx_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    // R5: no bit is reported while the slave holds the line
    assert_rx_not_driving_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> !drive_low);

    // R6: abort is a single-cycle event
    assert_abort_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        xact_abort |=> !xact_abort);

    // R2: presence does not start in the cycle the reset is recognised
    assert_presence_waits_R2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_reset |-> !drive_low);

    // R3: the committed speed moves only with a reset
    assert_speed_at_reset_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(od_mode) |-> bus_reset);

    // R7: a sleep request only appears when enabled
    assert_sleep_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sleep_req) |-> $past(sleep_en));
endmodule

bind owire_bit_phy owb_phy_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sleep_en   (sleep_en),
    .drive_low  (drive_low),
    .rx_valid   (rx_valid),
    .bus_reset  (bus_reset),
    .xact_abort (xact_abort),
    .od_mode    (od_mode),
    .sleep_req  (sleep_req)
);

// File: tb/owire_bit_phy_tb_top.sv
`timescale 1ns/1ps
module owire_bit_phy_tb_top;
    localparam int TICK_DIV = 8;
    localparam int T_SLP    = 200;

    typedef struct packed {
        logic       od;
        logic [1:0] kind;   // [1]=read slot, [0]=bit value
    } vec_t;

    localparam vec_t VECS [12] = '{
        '{1'b0, 2'd1}, '{1'b0, 2'd0}, '{1'b0, 2'd2}, '{1'b0, 2'd3},
        '{1'b0, 2'd1}, '{1'b1, 2'd0}, '{1'b1, 2'd1}, '{1'b1, 2'd2},
        '{1'b1, 2'd3}, '{1'b1, 2'd0}, '{1'b0, 2'd2}, '{1'b0, 2'd0}
    };

    logic clk = 1'b0, rst_n = 1'b0, us_tick = 1'b0;
    logic m_low = 1'b0, speed_sel = 1'b0, sleep_en = 1'b0;
    logic tx_en = 1'b0, tx_bit = 1'b1;
    logic drive_low, rx_valid, rx_bit, bus_reset, xact_abort, od_mode, sleep_req;
    logic line;
    assign line = ~(m_low | drive_low);

    always #2.5 clk = ~clk;

    owire_bit_phy #(.T_SLEEP(T_SLP)) dut_i (
        .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .line_in(line),
        .speed_sel(speed_sel), .sleep_en(sleep_en), .tx_en(tx_en), .tx_bit(tx_bit),
        .drive_low(drive_low), .rx_valid(rx_valid), .rx_bit(rx_bit),
        .bus_reset(bus_reset), .xact_abort(xact_abort), .od_mode(od_mode),
        .sleep_req(sleep_req)
    );

    int div = 0;
    always @(posedge clk) begin
        if (div == TICK_DIV - 1) begin div <= 0; us_tick <= 1'b1; end
        else begin div <= div + 1; us_tick <= 1'b0; end
    end

    int n_rx = 0, n_rst = 0, n_ab = 0, n_dt = 0;
    logic last_rx = 1'b0;
    always @(posedge clk) begin
        if (rx_valid) begin n_rx <= n_rx + 1; last_rx <= rx_bit; end
        if (bus_reset) n_rst <= n_rst + 1;
        if (xact_abort) n_ab <= n_ab + 1;
        if (us_tick && drive_low) n_dt <= n_dt + 1;
    end

    int total = 0, bad = 0;

    task automatic chk(input string req, input int act, input int lo, input int hi);
        total++;
        if (act < lo || act > hi) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d..%0d", req, act, lo, hi);
        end
    endtask

    task automatic wait_us(input int n);
        repeat (n) begin
            do @(negedge clk); while (!us_tick);
        end
    endtask

    task automatic do_reset(input logic od, input int low_us);
        int r0, dly, wid;
        r0 = n_rst;
        speed_sel = od;
        m_low = 1'b1;
        wait_us(low_us);
        m_low = 1'b0;
        dly = 0;
        while (!drive_low && dly < 400) begin wait_us(1); dly++; end
        wid = 0;
        while (drive_low && wid < 400) begin wait_us(1); wid++; end
        wait_us(2);
        chk("R1 reset pulse count", n_rst - r0, 1, 1);
        chk("R2 presence delay", dly, od ? 2 : 29, od ? 4 : 31);
        chk("R2 presence width", wid, od ? 15 : 119, od ? 17 : 121);
        chk("R3 committed speed", int'(od_mode), int'(od), int'(od));
    endtask

    task automatic do_slot(input logic od, input logic [1:0] kind, output logic seen);
        int lo, smp, len;
        tx_en  = kind[1];
        tx_bit = kind[0];
        len = od ? 8 : 70;
        if (kind[1]) begin lo = od ? 1 : 2; smp = od ? 2 : 15; end
        else begin lo = kind[0] ? (od ? 1 : 5) : (od ? 7 : 65); smp = lo; end
        m_low = 1'b1;
        wait_us(lo);
        m_low = 1'b0;
        if (smp > lo) wait_us(smp - lo);
        seen = line;
        wait_us(len - smp);
        wait_us(2);
        tx_en  = 1'b0;
        tx_bit = 1'b1;
    endtask

    initial begin
        logic cur_od, seen;
        int rx0, dt0, ab0, rs0;
        repeat (5) @(negedge clk);
        // R8: idle state after reset
        chk("R8 drive_low after reset", int'(drive_low), 0, 0);
        chk("R8 sleep_req after reset", int'(sleep_req), 0, 0);
        chk("R8 od_mode after reset", int'(od_mode), 0, 0);
        rst_n = 1'b1;
        wait_us(3);
        chk("R8 no events after reset", n_rx + n_rst + n_ab + n_dt, 0, 0);

        do_reset(1'b0, 500);
        cur_od = 1'b0;

        foreach (VECS[i]) begin
            if (VECS[i].od != cur_od) begin
                do_reset(VECS[i].od, VECS[i].od ? 60 : 500);
                cur_od = VECS[i].od;
            end
            rx0 = n_rx; dt0 = n_dt;
            do_slot(VECS[i].od, VECS[i].kind, seen);
            if (!VECS[i].kind[1]) begin
                chk("R4 write strobe count", n_rx - rx0, 1, 1);
                chk("R4 write bit", int'(last_rx), int'(VECS[i].kind[0]), int'(VECS[i].kind[0]));
            end else begin
                chk("R5 no strobe in read", n_rx - rx0, 0, 0);
                chk("R5 read bit seen by master", int'(seen), int'(VECS[i].kind[0]), int'(VECS[i].kind[0]));
                if (!VECS[i].kind[0])
                    chk("R5 read-0 hold ticks", n_dt - dt0, VECS[i].od ? 2 : 29, VECS[i].od ? 4 : 31);
                else
                    chk("R5 read-1 not driven", n_dt - dt0, 0, 0);
            end
        end

        // R6/R1: standard low beyond slot limit but short of reset
        ab0 = n_ab; rs0 = n_rst; dt0 = n_dt;
        m_low = 1'b1; wait_us(200); m_low = 1'b0; wait_us(150);
        chk("R6 std abort count", n_ab - ab0, 1, 1);
        chk("R1 short low no reset", n_rst - rs0, 0, 0);
        chk("R1 short low no presence", n_dt - dt0, 0, 0);

        // R6: overdrive abort between 16 and 48 ticks
        do_reset(1'b1, 60);
        ab0 = n_ab; rs0 = n_rst;
        m_low = 1'b1; wait_us(20); m_low = 1'b0; wait_us(20);
        chk("R6 od abort count", n_ab - ab0, 1, 1);
        chk("R1 od short low no reset", n_rst - rs0, 0, 0);

        // R3: speed-select change without reset keeps overdrive timing
        speed_sel = 1'b0;
        wait_us(2);
        rx0 = n_rx;
        do_slot(1'b1, 2'd0, seen);
        chk("R3 od write-0 after speed_sel change", int'(last_rx), 0, 0);
        chk("R3 od strobe after speed_sel change", n_rx - rx0, 1, 1);
        chk("R3 od_mode held", int'(od_mode), 1, 1);
        do_reset(1'b0, 500);

        // R7: sleep request
        sleep_en = 1'b0;
        m_low = 1'b1; wait_us(240);
        chk("R7 no sleep when disabled", int'(sleep_req), 0, 0);
        m_low = 1'b0; wait_us(5);
        sleep_en = 1'b1;
        m_low = 1'b1; wait_us(190);
        chk("R7 sleep not before limit", int'(sleep_req), 0, 0);
        wait_us(25);
        chk("R7 sleep after limit", int'(sleep_req), 1, 1);
        m_low = 1'b0; wait_us(1);
        chk("R7 sleep cleared by high", int'(sleep_req), 0, 0);
        sleep_en = 1'b0;

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule